// File: doc/BRIEF.md
# Latency-Aware Packet Transmit Source

This block is the sending side of a packet stream port. Packets come in beat by beat from a local write port with a full flag, which behaves like a small FIFO. They leave through a valid/data/sop/eop port. The sink at the other end announces readiness with a ready signal that has a fixed ready latency, set by a parameter to 1 or 2 cycles. The block may present a beat only in a ready cycle. A ready cycle is a cycle whose ready input was high exactly READY_LATENCY cycles before.

Back-pressure runs two ways:

- **Toward the local writer.** `in_full` is the only throttle. A push while it is high is dropped.
- **From the sink.** Ready falling removes the ready cycles READY_LATENCY cycles later. That stops the stream, including in the middle of a packet. Ready rising restores them after the same delay. Any beat already queued is then sent in the first ready cycle, with no bubble.

After reset, the block keeps valid low for a fixed number of cycles, even if the sink shows ready the whole time. The port outputs are driven from registers. For a ready latency of 2, the ready input also passes through a register before it is used.

Top module: `pkt_tx_source`

## Requirements
- R1: `tx_valid` is high in a cycle only if `tx_ready` was high exactly READY_LATENCY cycles earlier (a ready cycle). READY_LATENCY may be 1 or 2.
- R2: Once `tx_ready` has been low for two consecutive cycles, `tx_valid` is low in the cycle that follows.
- R3: In every ready cycle after the hold-off, `tx_valid` is high if a beat was queued in the previous cycle. A stalled packet therefore resumes within READY_LATENCY cycles of ready returning.
- R4: In the first HOLDOFF cycles after reset is released (default 2), `tx_valid` stays low whatever `tx_ready` does.
- R5: While reset is asserted, `tx_valid`, `tx_sop`, `tx_eop` and `in_full` are low, even with `tx_ready` high.
- R6: While `tx_valid` is low, `tx_data`, `tx_sop` and `tx_eop` keep the values they had in the previous cycle.
- R7: Beats leave in the order they were accepted, with data, sop and eop unchanged.
- R8: `in_full` is high exactly when DEPTH beats are queued. A push while `in_full` is high is dropped and does not change the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Beat payload from the local writer |
| in_sop | input | 1 | Beat is the first of a packet |
| in_eop | input | 1 | Beat is the last of a packet |
| in_push | input | 1 | Write the beat on `in_data`/`in_sop`/`in_eop` |
| in_full | output | 1 | Queue holds DEPTH beats; pushes are dropped |
| tx_ready | input | 1 | Sink readiness; grants the cycle READY_LATENCY later |
| tx_valid | output | 1 | Beat on `tx_data` is transferred this cycle |
| tx_data | output | DATA_W | Beat payload toward the sink |
| tx_sop | output | 1 | Transferred beat starts a packet |
| tx_eop | output | 1 | Transferred beat ends a packet |

## Verification
The hardest case to reach from the ports is a ready drop in the middle of a packet that lands exactly when the queue is about to run dry. The stop deadline, the restart deadline and the hold-off then interact at the same edges. The stimulus first holds ready high through reset and release while packets are pushed at once. It then fills the queue with ready low and keeps pushing to provoke drops. Next it runs short, regular ready gaps of one and two cycles across multi-beat packets. A long random stretch of ready and push activity follows, and the run ends with a drain.

// File: rtl/rlt_pkg.sv
package rlt_pkg;

  // Framing marks that travel with every beat.
  typedef struct packed {
    logic sop;
    logic eop;
  } rlt_mark_t;

endpackage

// File: rtl/rlt_beat_fifo.sv
module rlt_beat_fifo
  import rlt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  rlt_mark_t         push_mark,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output rlt_mark_t         head_mark,
  output logic              empty,
  output logic              full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] data_mem [DEPTH];
  rlt_mark_t         mark_mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     level;
  logic              wr_en, rd_en;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
  assign wr_en = push && !full;
  assign rd_en = pop && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= step(wr_ptr);
      if (rd_en) rd_ptr <= step(rd_ptr);
      if (wr_en && !rd_en)      level <= level + CW'(1);
      else if (rd_en && !wr_en) level <= level - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_ptr] <= push_data;
      mark_mem[wr_ptr] <= push_mark;
    end
  end

  assign head_data = data_mem[rd_ptr];
  assign head_mark = mark_mem[rd_ptr];

endmodule

// File: rtl/rlt_ready_line.sv
module rlt_ready_line #(
  parameter int READY_LATENCY = 2,
  parameter int HOLDOFF       = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sink_ready,
  output logic grant,   // next cycle is a ready cycle
  output logic armed    // hold-off after reset has elapsed
);

  localparam int HW = (HOLDOFF < 1) ? 1 : $clog2(HOLDOFF + 1);

  generate
    if (READY_LATENCY <= 1) begin : g_direct
      assign grant = sink_ready;
    end else begin : g_line
      logic [READY_LATENCY-1:1] line;
      always_ff @(posedge clk) begin
        if (rst) begin
          line <= '0;
        end else begin
          line[1] <= sink_ready;
          for (int k = 2; k < READY_LATENCY; k++) line[k] <= line[k-1];
        end
      end
      assign grant = line[READY_LATENCY-1];
    end
  endgenerate

  logic [HW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst)                          wait_cnt <= '0;
    else if (wait_cnt != HW'(HOLDOFF)) wait_cnt <= wait_cnt + HW'(1);
  end

  assign armed = (wait_cnt == HW'(HOLDOFF));

endmodule

// File: rtl/rlt_launch.sv
module rlt_launch
  import rlt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant,
  input  logic              armed,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_data,
  input  rlt_mark_t         q_mark,
  output logic              pop,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_eop
);

  assign pop = grant && armed && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_sop   <= 1'b0;
      tx_eop   <= 1'b0;
    end else begin
      tx_valid <= pop;
      if (pop) begin
        tx_data <= q_data;
        tx_sop  <= q_mark.sop;
        tx_eop  <= q_mark.eop;
      end
    end
  end

endmodule

// File: rtl/pkt_tx_source.sv
module pkt_tx_source
  import rlt_pkg::*;
#(
  parameter int DATA_W        = 64,
  parameter int DEPTH         = 8,
  parameter int READY_LATENCY = 2,
  parameter int HOLDOFF       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_push,
  output logic              in_full,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_eop
);

  logic              q_empty;
  logic              q_pop;
  logic [DATA_W-1:0] q_data;
  rlt_mark_t         q_mark;
  rlt_mark_t         in_mark;
  logic              grant;
  logic              armed;

  assign in_mark = '{sop: in_sop, eop: in_eop};

  rlt_beat_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (in_push),
    .push_data (in_data),
    .push_mark (in_mark),
    .pop       (q_pop),
    .head_data (q_data),
    .head_mark (q_mark),
    .empty     (q_empty),
    .full      (in_full)
  );

  rlt_ready_line #(.READY_LATENCY(READY_LATENCY), .HOLDOFF(HOLDOFF)) u_line (
    .clk        (clk),
    .rst        (rst),
    .sink_ready (tx_ready),
    .grant      (grant),
    .armed      (armed)
  );

  rlt_launch #(.DATA_W(DATA_W)) u_launch (
    .clk      (clk),
    .rst      (rst),
    .grant    (grant),
    .armed    (armed),
    .q_empty  (q_empty),
    .q_data   (q_data),
    .q_mark   (q_mark),
    .pop      (q_pop),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_sop   (tx_sop),
    .tx_eop   (tx_eop)
  );

endmodule

// File: rtl/pkt_tx_source_chk.sv
module pkt_tx_source_chk #(
  parameter int DATA_W        = 64,
  parameter int READY_LATENCY = 2,
  parameter int HOLDOFF       = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_ready,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_sop,
  input logic              tx_eop,
  input logic              in_full,
  input logic              q_empty
);

  localparam int AGW = $clog2(HOLDOFF + 2) + 1;

  logic [READY_LATENCY-1:0] seen;
  logic [1:0]               low_run;
  logic [AGW-1:0]           age;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= '0;
      low_run <= '0;
      age     <= '0;
    end else begin
      seen[0] <= tx_ready;
      for (int k = 1; k < READY_LATENCY; k++) seen[k] <= seen[k-1];
      if (tx_ready)              low_run <= '0;
      else if (low_run != 2'd3)  low_run <= low_run + 2'd1;
      if (age <= AGW'(HOLDOFF))  age <= age + AGW'(1);
    end
  end

  assert_valid_in_ready_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> seen[READY_LATENCY-1]);

  assert_stop_deadline_R2: assert property (@(posedge clk) disable iff (rst)
    (low_run >= 2'd2) |-> !tx_valid);

  assert_restart_no_bubble_R3: assert property (@(posedge clk) disable iff (rst)
    (seen[READY_LATENCY-1] && (age > AGW'(HOLDOFF)) && ($past(q_empty) == 1'b0)) |-> tx_valid);

  assert_holdoff_R4: assert property (@(posedge clk) disable iff (rst)
    (age <= AGW'(HOLDOFF)) |-> !tx_valid);

  assert_reset_quiet_R5: assert property (@(posedge clk)
    rst |=> (!tx_valid && !tx_sop && !tx_eop && !in_full));

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |-> $stable({tx_data, tx_sop, tx_eop}));

endmodule

bind pkt_tx_source pkt_tx_source_chk #(
  .DATA_W(DATA_W), .READY_LATENCY(READY_LATENCY), .HOLDOFF(HOLDOFF)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_ready (tx_ready),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .tx_sop   (tx_sop),
  .tx_eop   (tx_eop),
  .in_full  (in_full),
  .q_empty  (q_empty)
);

// File: tb/pkt_tx_source_test.sv
module pkt_tx_source_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 4;
  localparam int RL    = 2;
  localparam int HOLD  = 2;
  localparam int NCYC  = 3000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic          in_sop = 1'b0, in_eop = 1'b0, in_push = 1'b0;
  logic          in_full;
  logic          tx_ready = 1'b0;
  logic          tx_valid;
  logic [DW-1:0] tx_data;
  logic          tx_sop, tx_eop;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_tx_source #(.DATA_W(DW), .DEPTH(DEPTH), .READY_LATENCY(RL), .HOLDOFF(HOLD)) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .in_push(in_push), .in_full(in_full), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop)
  );

  typedef logic [DW+1:0] beat_t;   // {sop, eop, data}

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  beat_t mq[$];
  logic  rh[0:3];
  int    ho, low_run;
  logic  exp_valid;
  beat_t exp_beat, last_out;
  logic [DW-1:0] gen_data;
  int    gen_left;
  logic  gen_first;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic pick_ready(input int i);
    if (i < 40)        return 1'b1;
    if (i < 80)        return 1'b0;
    if (i < 200)       return (i % 5) != 0;
    if (i < 320)       return ((i / 2) % 2) == 0;
    if (i < NCYC - 100) return $urandom_range(0, 99) < 60;
    return 1'b1;
  endfunction

  function automatic logic pick_push(input int i);
    if (i < 80)         return 1'b1;
    if (i < NCYC - 100) return $urandom_range(0, 99) < 70;
    return 1'b0;
  endfunction

  initial begin
    repeat (NCYC + 500) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", NCYC + 500, NCYC);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic grant, pop, full_now, accept;
    int   ho_pre, low_pre;
    void'($urandom(32'd4242));
    rst = 1'b1;
    tx_ready = 1'b1;   // sink shows ready during reset
    repeat (4) @(negedge clk);
    // R5: reset state with ready high
    check(tx_valid == 1'b0, "R5", "valid in reset", 64'(tx_valid), 0);
    check({tx_sop, tx_eop} == 2'b00, "R5", "sop/eop in reset", 64'({tx_sop, tx_eop}), 0);
    check(in_full == 1'b0, "R5", "full in reset", 64'(in_full), 0);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) rh[k] = 1'b0;
    ho = 0; low_run = 0; exp_valid = 1'b0;
    last_out = {tx_sop, tx_eop, tx_data};
    gen_data = 16'h0100; gen_left = 3; gen_first = 1'b1;

    for (int i = 0; i < NCYC; i++) begin
      full_now = (mq.size() == DEPTH);
      // R8: full flag tracks queue level
      check(in_full == full_now, "R8", "in_full", 64'(in_full), 64'(full_now));
      tx_ready = pick_ready(i);
      in_push  = pick_push(i);
      in_data  = gen_data;
      in_sop   = gen_first;
      in_eop   = (gen_left == 1);
      // model of the coming edge
      ho_pre  = ho;
      low_pre = low_run;
      grant = (RL == 1) ? tx_ready : rh[RL-2];
      pop   = grant && (ho >= HOLD) && (mq.size() > 0);
      exp_valid = pop;
      if (pop) exp_beat = mq.pop_front();
      accept = in_push && !full_now;   // R8: pushes while full are dropped
      if (accept) begin
        mq.push_back({in_sop, in_eop, in_data});
        gen_data++;
        gen_left--;
        gen_first = 1'b0;
        if (gen_left == 0) begin
          gen_left  = $urandom_range(1, 5);
          gen_first = 1'b1;
        end
      end
      for (int k = 3; k > 0; k--) rh[k] = rh[k-1];
      rh[0] = tx_ready;
      if (ho < HOLD) ho++;
      low_run = tx_ready ? 0 : low_run + 1;
      @(negedge clk);
      if (ho_pre < HOLD)
        check(tx_valid == exp_valid, "R4", "valid during hold-off", 64'(tx_valid), 64'(exp_valid));
      else if (!exp_valid && low_pre >= 1 && !tx_ready)
        check(tx_valid == exp_valid, "R2", "valid after ready drop", 64'(tx_valid), 64'(exp_valid));
      else if (exp_valid)
        check(tx_valid == exp_valid, "R3", "valid in ready cycle", 64'(tx_valid), 64'(exp_valid));
      else
        check(tx_valid == exp_valid, "R1", "valid outside ready cycle", 64'(tx_valid), 64'(exp_valid));
      if (exp_valid)
        check({tx_sop, tx_eop, tx_data} == exp_beat, "R7", "beat content/order",
              64'({tx_sop, tx_eop, tx_data}), 64'(exp_beat));
      else
        check({tx_sop, tx_eop, tx_data} == last_out, "R6", "idle hold",
              64'({tx_sop, tx_eop, tx_data}), 64'(last_out));
      last_out = {tx_sop, tx_eop, tx_data};
    end
    check(mq.size() == 0, "R7", "queue drained", 64'(mq.size()), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule